// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block bridges a single-access internal request port to an asynchronous external memory bus. The external bus has eight dedicated pins for the upper address byte and eight shared pins that first carry the low address byte and then the data. An address latch enable pulse lets an external latch capture the low address byte before the shared pins change meaning. Active-low read and write strobes frame the data phase.

The external address space is split into a lower and an upper sector at a programmable boundary, and each sector has its own two-bit wait code. The wait code sets how many clock periods the strobe stays asserted and whether a hold period follows it. Two sectors can therefore serve two memory devices that need different timing. A request is accepted when the block is idle or in the final cycle of an access, so accesses can run back to back. Read data is returned with a one-cycle done pulse. An optional bus keeper drives the last value onto the shared pins between accesses; without it the pins are released.

Configuration is written through a small port with a single write strobe. The wait code of an access is taken at the edge that accepts it, so a later configuration write does not alter an access already under way.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset, both strobes are high, the latch enable is low, the shared pins are released (`bus_ad_oe` = 0), `rsp_done` is low, `req_ready` is high, the keeper is off, the boundary is 0x80 and both wait codes are 00, so the first access takes three cycles.
- R2: During every cycle of an access (address, strobe and hold cycles) `bus_hi` carries bits 15..8 of the request address.
- R3: `bus_ale` is high in exactly one cycle per access, the first, with bits 7..0 of the address driven on the shared pins and both strobes high; it is low in all other cycles.
- R4: The strobe phase starts in the cycle after the latch enable pulse. Exactly one strobe is low: `bus_wr_n` when `req_we` = 1, `bus_rd_n` when `req_we` = 0. It stays low for 2 + E cycles, where E is 0 for wait code 00, 1 for code 01, and 2 for codes 10 and 11.
- R5: Wait code 11 adds one hold cycle after the strobe phase. In that cycle both strobes are high while the upper address and the shared-pin drive state of the strobe phase remain unchanged.
- R6: An access whose address bits 15..8 are greater than or equal to the boundary uses the upper-sector wait code; any other access uses the lower-sector code.
- R7: A write drives its data on the shared pins for the whole strobe phase; a read releases the shared pins for the whole strobe phase.
- R8: Read data present on `bus_ad_in` at the clock edge that closes the strobe phase appears on `rsp_rdata`. `rsp_done` is high for exactly one cycle, the cycle after the strobe phase, for reads and writes.
- R9: `req_ready` is high when idle and in the final cycle of an access (the last strobe cycle, or the hold cycle for code 11), and low otherwise. A request accepted in the final cycle puts its latch enable pulse in the very next cycle.
- R10: With the keeper on and at least one access completed, idle cycles drive the shared pins with the last value they carried: the written data after a write, the read data after a read. With the keeper off, idle cycles release the pins.
- R11: A `cfg_we` pulse loads both wait codes, the boundary and the keeper enable at the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Request accepted at this edge if valid |
| rsp_rdata | output | 8 | Last read data |
| rsp_done | output | 1 | One-cycle access-complete pulse |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wait_lo | input | 2 | Lower-sector wait code |
| cfg_wait_hi | input | 2 | Upper-sector wait code |
| cfg_bound | input | 8 | Sector boundary on address bits 15..8 |
| cfg_keep | input | 1 | Bus keeper enable |
| bus_hi | output | 8 | Upper address pins |
| bus_ad_out | output | 8 | Shared pins, outgoing value |
| bus_ad_oe | output | 1 | Shared pins drive enable |
| bus_ad_in | input | 8 | Shared pins, incoming value |
| bus_ale | output | 1 | Address latch enable |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |

## Verification
The case where two functions share a cycle is back-to-back traffic. The done pulse and, for a read, the returned data of one access fall in the same cycle as the latch enable pulse and the new low address of the next access. The bench holds `req_valid` high across consecutive requests, under every wait code including the hold code, so that each one is accepted in the previous access's final cycle. A per-cycle expectation table built from the requirements is checked against every pin, and `rsp_rdata` is checked against a memory model that the bench runs from the bus pins.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_STRB = 2'd2,
    PH_HOLD = 2'd3
  } xb_phase_e;

  localparam int CODE_W = 2;
  localparam int CNT_W  = 2;

  // Strobe cycles added beyond the base two.
  function automatic logic [CNT_W-1:0] strobe_extra(input logic [CODE_W-1:0] code);
    case (code)
      2'b00:   strobe_extra = 2'd0;
      2'b01:   strobe_extra = 2'd1;
      default: strobe_extra = 2'd2;
    endcase
  endfunction

  function automatic logic wants_hold(input logic [CODE_W-1:0] code);
    wants_hold = (code == 2'b11);
  endfunction

endpackage

// File: rtl/xbus_cfg.sv
module xbus_cfg
  import xbus_pkg::*;
#(
  parameter int HW = 8,
  parameter logic [HW-1:0] BOUND_RST = 8'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CODE_W-1:0] cfg_wait_lo,
  input  logic [CODE_W-1:0] cfg_wait_hi,
  input  logic [HW-1:0]     cfg_bound,
  input  logic              cfg_keep,
  input  logic [HW-1:0]     lookup_hi,
  output logic [CODE_W-1:0] sel_code,
  output logic              keep_on
);

  logic [CODE_W-1:0] wait_lo_q, wait_hi_q;
  logic [HW-1:0]     bound_q;
  logic              keep_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_lo_q <= '0;
      wait_hi_q <= '0;
      bound_q   <= BOUND_RST;
      keep_q    <= 1'b0;
    end else if (cfg_we) begin
      wait_lo_q <= cfg_wait_lo;
      wait_hi_q <= cfg_wait_hi;
      bound_q   <= cfg_bound;
      keep_q    <= cfg_keep;
    end
  end

  logic upper_hit;
  assign upper_hit = (lookup_hi >= bound_q);
  assign sel_code  = upper_hit ? wait_hi_q : wait_lo_q;
  assign keep_on   = keep_q;

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (bound_q == $past(cfg_bound)) && (keep_q == $past(cfg_keep))); // R11

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [CODE_W-1:0] sel_code,
  output xb_phase_e         phase_nx,
  output logic              ready,
  output logic              ev_start,
  output logic              ev_strobe,
  output logic              ev_end
);

  xb_phase_e         phase_q;
  logic [CNT_W-1:0]  cnt_q, cnt_nx;
  logic [CODE_W-1:0] code_q;
  logic              last_strobe, final_cyc;

  assign last_strobe = (phase_q == PH_STRB) && (cnt_q == '0);
  assign final_cyc   = (last_strobe && !wants_hold(code_q)) || (phase_q == PH_HOLD);
  assign ready       = (phase_q == PH_IDLE) || final_cyc;
  assign ev_start    = req_valid && ready;
  assign ev_strobe   = (phase_q == PH_ADDR);
  assign ev_end      = last_strobe;

  always_comb begin
    phase_nx = phase_q;
    cnt_nx   = cnt_q;
    unique case (phase_q)
      PH_IDLE: if (ev_start) phase_nx = PH_ADDR;
      PH_ADDR: begin
        phase_nx = PH_STRB;
        cnt_nx   = CNT_W'(1) + strobe_extra(code_q);
      end
      PH_STRB: begin
        if (cnt_q != '0)             cnt_nx   = cnt_q - CNT_W'(1);
        else if (wants_hold(code_q)) phase_nx = PH_HOLD;
        else                         phase_nx = ev_start ? PH_ADDR : PH_IDLE;
      end
      PH_HOLD: phase_nx = ev_start ? PH_ADDR : PH_IDLE;
      default: phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      code_q  <= '0;
    end else begin
      phase_q <= phase_nx;
      cnt_q   <= cnt_nx;
      if (ev_start) code_q <= sel_code;
    end
  end

  AST_ADDR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_ADDR) |=> (phase_q == PH_STRB)); // R3

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_ADDR) |-> !ready); // R9

endmodule

// File: rtl/xbus_pads.sv
module xbus_pads
  import xbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  localparam int HW = AW - DW
) (
  input  logic          clk,
  input  logic          rst,
  input  xb_phase_e     phase_nx,
  input  logic          ev_start,
  input  logic          ev_strobe,
  input  logic          ev_end,
  input  logic          keep_on,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] ad_in,
  output logic [HW-1:0] hi_q,
  output logic [DW-1:0] ad_q,
  output logic          oe_q,
  output logic          ale_q,
  output logic          rd_n_q,
  output logic          wr_n_q,
  output logic [DW-1:0] rdata_q,
  output logic          done_q
);

  logic          we_q;
  logic [DW-1:0] wd_q;
  logic          have_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q      <= '0;
      ad_q      <= '0;
      oe_q      <= 1'b0;
      ale_q     <= 1'b0;
      rd_n_q    <= 1'b1;
      wr_n_q    <= 1'b1;
      rdata_q   <= '0;
      done_q    <= 1'b0;
      we_q      <= 1'b0;
      wd_q      <= '0;
      have_last <= 1'b0;
    end else begin
      done_q <= ev_end;
      if (ev_end) begin
        have_last <= 1'b1;
        if (!we_q) begin
          rdata_q <= ad_in;
          ad_q    <= ad_in;
        end
      end
      unique case (phase_nx)
        PH_ADDR: begin
          if (ev_start) begin
            ale_q  <= 1'b1;
            rd_n_q <= 1'b1;
            wr_n_q <= 1'b1;
            oe_q   <= 1'b1;
            hi_q   <= req_addr[AW-1:DW];
            ad_q   <= req_addr[DW-1:0];
            we_q   <= req_we;
            wd_q   <= req_wdata;
          end
        end
        PH_STRB: begin
          ale_q <= 1'b0;
          if (ev_strobe) begin
            rd_n_q <= we_q;
            wr_n_q <= !we_q;
            oe_q   <= we_q;
            if (we_q) ad_q <= wd_q;
          end
        end
        PH_HOLD: begin
          rd_n_q <= 1'b1;
          wr_n_q <= 1'b1;
        end
        default: begin
          ale_q  <= 1'b0;
          rd_n_q <= 1'b1;
          wr_n_q <= 1'b1;
          oe_q   <= keep_on && (have_last || ev_end);
        end
      endcase
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n_q && !wr_n_q)); // R4

  AST_ALE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ale_q |-> (rd_n_q && wr_n_q && oe_q)); // R3

  AST_RD_AFTER_ALE: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_n_q) |-> $past(ale_q)); // R4

  AST_WR_AFTER_ALE: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_n_q) |-> $past(ale_q)); // R4

  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (rst)
    !wr_n_q |-> oe_q); // R7

  AST_READ_RELEASES: assert property (@(posedge clk) disable iff (rst)
    !rd_n_q |-> !oe_q); // R7

  AST_HI_STABLE: assert property (@(posedge clk) disable iff (rst)
    ((!rd_n_q || !wr_n_q) && $past(!rd_n_q || !wr_n_q)) |-> $stable(hi_q)); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R8

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  localparam int HW = AW - DW,
  parameter logic [HW-1:0] BOUND_RST = 8'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              req_ready,
  output logic [DW-1:0]     rsp_rdata,
  output logic              rsp_done,
  input  logic              cfg_we,
  input  logic [CODE_W-1:0] cfg_wait_lo,
  input  logic [CODE_W-1:0] cfg_wait_hi,
  input  logic [HW-1:0]     cfg_bound,
  input  logic              cfg_keep,
  output logic [HW-1:0]     bus_hi,
  output logic [DW-1:0]     bus_ad_out,
  output logic              bus_ad_oe,
  input  logic [DW-1:0]     bus_ad_in,
  output logic              bus_ale,
  output logic              bus_rd_n,
  output logic              bus_wr_n
);

  logic [CODE_W-1:0] sel_code;
  logic              keep_on;
  xb_phase_e         phase_nx;
  logic              ev_start, ev_strobe, ev_end;

  xbus_cfg #(.HW(HW), .BOUND_RST(BOUND_RST)) u_cfg (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_wait_lo(cfg_wait_lo), .cfg_wait_hi(cfg_wait_hi),
    .cfg_bound(cfg_bound), .cfg_keep(cfg_keep),
    .lookup_hi(req_addr[AW-1:DW]),
    .sel_code(sel_code), .keep_on(keep_on)
  );

  xbus_seq u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .sel_code(sel_code),
    .phase_nx(phase_nx), .ready(req_ready),
    .ev_start(ev_start), .ev_strobe(ev_strobe), .ev_end(ev_end)
  );

  xbus_pads #(.AW(AW), .DW(DW)) u_pads (
    .clk(clk), .rst(rst),
    .phase_nx(phase_nx), .ev_start(ev_start), .ev_strobe(ev_strobe), .ev_end(ev_end),
    .keep_on(keep_on), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .ad_in(bus_ad_in),
    .hi_q(bus_hi), .ad_q(bus_ad_out), .oe_q(bus_ad_oe), .ale_q(bus_ale),
    .rd_n_q(bus_rd_n), .wr_n_q(bus_wr_n), .rdata_q(rsp_rdata), .done_q(rsp_done)
  );

  AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_rd_n) |-> rsp_done); // R8

endmodule

// File: tb/xbus_ctrl_bench.sv
module xbus_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready;
  logic [7:0]  rsp_rdata;
  logic        rsp_done;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_wait_lo = '0, cfg_wait_hi = '0;
  logic [7:0]  cfg_bound = 8'h80;
  logic        cfg_keep = 1'b0;
  logic [7:0]  bus_hi, bus_ad_out, bus_ad_in;
  logic        bus_ad_oe, bus_ale, bus_rd_n, bus_wr_n;

  always #10 clk = ~clk;

  xbus_ctrl u_xbus_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
    .cfg_we(cfg_we), .cfg_wait_lo(cfg_wait_lo), .cfg_wait_hi(cfg_wait_hi),
    .cfg_bound(cfg_bound), .cfg_keep(cfg_keep),
    .bus_hi(bus_hi), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in),
    .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n)
  );

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  function automatic logic [7:0] init_val(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // External memory model driven only by the bus pins.
  logic [7:0]  ext_mem [int];
  logic [15:0] lat = '0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (bus_ale) lat = {bus_hi, bus_ad_out};
    if (!bus_wr_n) ext_mem[int'(lat)] = bus_ad_out;
    bus_ad_in <= ext_mem.exists(int'(lat)) ? ext_mem[int'(lat)] : init_val(lat);
  end

  // Reference state
  logic [7:0] ref_mem [int];
  logic [1:0] m_lo = 2'b00, m_hi = 2'b00;
  logic [7:0] m_bound = 8'h80;
  bit         m_keep = 0, any_done = 0;
  logic [7:0] last_val = '0;
  int         settle = 0;
  bit         checking = 0;

  typedef struct {
    bit ale, rd_n, wr_n, oe, rdy, chk_ad;
    logic [7:0] ad, hi;
    string tag;
  } exp_t;
  exp_t       exp_q [int];
  logic [7:0] done_val [int];
  bit         done_rd [int];

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cycle %0d actual=%0h expected=%0h", tag, cyc, act, expv);
    end
  endtask

  task automatic sched(input int x, input bit we, input logic [15:0] a, input logic [7:0] wd);
    logic [1:0] code;
    int s, e;
    bit hold;
    logic [7:0] rv;
    exp_t t;
    code = (a[15:8] >= m_bound) ? m_hi : m_lo;       // R6 sector pick
    e    = (code == 2'b00) ? 0 : (code == 2'b01) ? 1 : 2;
    s    = 2 + e;                                     // R4 strobe length
    hold = (code == 2'b11);                           // R5
    t = '{ale:1, rd_n:1, wr_n:1, oe:1, rdy:0, chk_ad:1, ad:a[7:0], hi:a[15:8], tag:"R3 address"};
    exp_q[x] = t;
    for (int k = 1; k <= s; k++) begin
      t = '{ale:0, rd_n:we, wr_n:!we, oe:we, rdy:(k == s) && !hold, chk_ad:we, ad:wd, hi:a[15:8], tag:"R4 strobe"};
      exp_q[x + k] = t;
    end
    if (hold) begin
      t = '{ale:0, rd_n:1, wr_n:1, oe:we, rdy:1, chk_ad:we, ad:wd, hi:a[15:8], tag:"R5 hold"};
      exp_q[x + s + 1] = t;
    end
    if (we) begin
      ref_mem[int'(a)] = wd;
      rv = wd;
    end else begin
      rv = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : init_val(a);
    end
    done_val[x + s + 1] = rv;
    done_rd[x + s + 1]  = !we;
  endtask

  // Per-cycle comparison against the expectation table
  always @(negedge clk) begin
    if (checking) begin
      if (settle > 0) settle--;
      if (done_val.exists(cyc)) begin
        chk(rsp_done == 1'b1, "R8 done pulse", rsp_done, 1);
        if (done_rd[cyc]) chk(rsp_rdata == done_val[cyc], "R8 read data", rsp_rdata, done_val[cyc]);
        last_val = done_val[cyc];
        any_done = 1;
        done_val.delete(cyc);
        done_rd.delete(cyc);
      end else begin
        chk(rsp_done == 1'b0, "R8 no done", rsp_done, 0);
      end
      if (exp_q.exists(cyc)) begin
        exp_t e;
        e = exp_q[cyc];
        chk(bus_ale == e.ale, {e.tag, " R3 ale"}, bus_ale, e.ale);
        chk(bus_rd_n == e.rd_n && bus_wr_n == e.wr_n, {e.tag, " R4 strobes"},
            {bus_rd_n, bus_wr_n}, {e.rd_n, e.wr_n});
        chk(bus_ad_oe == e.oe, {e.tag, " R7 drive"}, bus_ad_oe, e.oe);
        chk(bus_hi == e.hi, {e.tag, " R2 upper address"}, bus_hi, e.hi);
        chk(req_ready == e.rdy, {e.tag, " R9 ready"}, req_ready, e.rdy);
        if (e.chk_ad) chk(bus_ad_out == e.ad, {e.tag, " R7 shared pins"}, bus_ad_out, e.ad);
        exp_q.delete(cyc);
      end else begin
        chk(bus_ale == 1'b0, "R3 idle ale", bus_ale, 0);
        chk(bus_rd_n && bus_wr_n, "R4 idle strobes", {bus_rd_n, bus_wr_n}, 2'b11);
        chk(req_ready == 1'b1, "R9 idle ready", req_ready, 1);
        if (settle == 0) begin
          chk(bus_ad_oe == (m_keep && any_done), "R10 idle drive", bus_ad_oe, m_keep && any_done);
          if (m_keep && any_done)
            chk(bus_ad_out == last_val, "R10 kept value", bus_ad_out, last_val);
        end
      end
    end
  end

  task automatic access(input bit we, input logic [15:0] a, input logic [7:0] wd);
    @(negedge clk);
    req_valid = 1'b1;
    req_we    = we;
    req_addr  = a;
    req_wdata = wd;
    while (!req_ready) @(negedge clk);
    sched(cyc + 1, we, a, wd);
    @(posedge clk);
  endtask

  task automatic release_req(input int gap);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] lo, input logic [1:0] hi, input logic [7:0] b, input bit k);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wait_lo = lo; cfg_wait_hi = hi; cfg_bound = b; cfg_keep = k;
    m_lo = lo; m_hi = hi; m_bound = b; m_keep = k;  // R11
    settle = 3;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(bus_rd_n && bus_wr_n, "R1 strobes high", {bus_rd_n, bus_wr_n}, 2'b11);
    chk(bus_ale == 1'b0, "R1 ale low", bus_ale, 0);
    chk(bus_ad_oe == 1'b0, "R1 pins released", bus_ad_oe, 0);
    chk(rsp_done == 1'b0, "R1 done low", rsp_done, 0);
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    checking = 1;

    // R1: default codes 00, three-cycle access
    access(1, 16'h1234, 8'hA5); release_req(4);
    access(0, 16'h1234, 8'h00); release_req(4);

    // R6 boundary compare, R4 code 01, R5 code 11 on equality
    set_cfg(2'b01, 2'b11, 8'h40, 0); release_req(2);
    access(0, 16'h3000, 8'h00); release_req(3);
    access(1, 16'h4000, 8'h77); release_req(3);
    access(0, 16'h4000, 8'h00); release_req(3);
    access(0, 16'h3FFF, 8'h00); release_req(3);

    // R4 code 10 in lower sector, 00 in upper
    set_cfg(2'b10, 2'b00, 8'hF0, 0); release_req(2);
    access(1, 16'h2000, 8'h11); release_req(3);
    access(0, 16'hF100, 8'h00); release_req(3);

    // R9 back-to-back with done and ALE in one cycle
    access(1, 16'h0101, 8'hC3);
    access(0, 16'h0101, 8'h00);
    access(1, 16'hF0F0, 8'h9E);
    access(0, 16'hF0F0, 8'h00);
    access(0, 16'h0055, 8'h00);
    release_req(4);

    // R10 keeper on: read then write values held while idle
    set_cfg(2'b10, 2'b00, 8'hF0, 1); release_req(3);
    access(0, 16'h0777, 8'h00); release_req(6);
    access(1, 16'hF200, 8'h3C); release_req(6);
    access(0, 16'hF200, 8'h00); access(1, 16'h0010, 8'h81); release_req(5);
    set_cfg(2'b10, 2'b00, 8'hF0, 0); release_req(5);

    // R5 hold cycle with back-to-back traffic
    set_cfg(2'b01, 2'b11, 8'h80, 1); release_req(2);
    access(1, 16'h9000, 8'h5C);
    access(0, 16'h9000, 8'h00);
    access(0, 16'h1000, 8'h00);
    access(1, 16'hA0A0, 8'hE7);
    release_req(6);

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d actual=hung expected=complete", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule